// File: doc/BRIEF.md
# Mute and Power-Down Sequencing Controller

This block sets the power state of an audio capture front end. It drives separate enables for the shared references (bandgap, voltage reference, common-mode), for each ADC channel and for each microphone-bias output. Its inputs are two ranked global power-down levels, a power-down bit for each block, and an external mute pin. The configuration values come in as plain input ports.

The deep level (`pdn_deep`) switches off the references as well as every channel. The shallow level (`pdn_shallow`) switches off the channels and bias outputs but keeps the references running. A settle counter holds every channel enable low until the references have been up for `REF_SETTLE_CYCLES` clocks. To power up deterministically, firmware sets both levels, clears the deep level, waits for the settle time, and then clears the shallow level.

The mute pin passes through a synchronizer and then raises a mute request toward the volume-ramp logic. The pin can also switch off a chosen set of channels and bias outputs, selected by two mask vectors. When soft ramping is enabled, that power-down waits for the ramp logic to report completion. On release, power comes back first and the unmute request follows.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every output (`ref_en`, `ref_ready`, `adc_en`, `bias_en`, `mute_req`) reads 0 after that edge.
- R2: With `pdn_deep` high at an edge, `ref_en`, `ref_ready`, all `adc_en` bits and all `bias_en` bits are 0 after that edge.
- R3: With `pdn_shallow` high and `pdn_deep` low at an edge, `ref_en` is 1 and all `adc_en` and `bias_en` bits are 0 after that edge. `ref_ready` keeps its settled value.
- R4: `ref_ready` rises exactly `REF_SETTLE_CYCLES` edges after the edge on which `ref_en` rises. It falls on the same edge as `ref_en`.
- R5: `adc_en[i]` is 1 one edge after a cycle in which all of the following hold: both global levels are low, `ref_ready` is 1, `adc_pdn[i]` is 0, and a mute power-down is not holding channel i through `mute_adc_mask[i]`. Otherwise it is 0.
- R6: `bias_en[j]` follows the same rule as R5, using `bias_pdn[j]` and `mute_bias_mask[j]`.
- R7: `mute_req` rises on the third clock edge after `mute_pin` goes high. The pin passes through two synchronizer flops and then the sequencer flop.
- R8: With `soft_ramp_en` = 1, mute-driven power-down is applied only on the edge where `ramp_done` is sampled high while the mute request is pending. The masked enables fall one edge later.
- R9: With `soft_ramp_en` = 0, the mute power-down is applied on the same edge that raises `mute_req`. The masked enables fall one edge later.
- R10: On pin release from the muted state, the mute power-down is lifted on the third edge. The enables return one edge later. `mute_req` falls `UNMUTE_HOLD` edges after the lift, so the enables return before the request drops.
- R11: Channels and bias outputs whose mask bit is 0 are not affected by mute.
- R12: If the pin is released before `ramp_done` arrives, no power-down is applied and `mute_req` falls on the third edge after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mute_pin | input | 1 | Asynchronous external mute request, active high |
| pdn_deep | input | 1 | Global deep power-down: references and all blocks off |
| pdn_shallow | input | 1 | Global shallow power-down: blocks off, references kept |
| adc_pdn | input | NUM_ADC | Power-down bit for each ADC channel |
| bias_pdn | input | NUM_BIAS | Power-down bit for each bias output |
| mute_adc_mask | input | NUM_ADC | ADC channels switched off while muted |
| mute_bias_mask | input | NUM_BIAS | Bias outputs switched off while muted |
| soft_ramp_en | input | 1 | Wait for the volume ramp before applying mute power-down |
| ramp_done | input | 1 | Completion pulse from the volume-ramp logic |
| ref_en | output | 1 | Reference block enable |
| ref_ready | output | 1 | References settled |
| adc_en | output | NUM_ADC | ADC channel enables |
| bias_en | output | NUM_BIAS | Bias output enables |
| mute_req | output | 1 | Mute request toward the volume-ramp logic |

## Verification
The sequencing is driven in several patterns, each chosen to separate cases that a single pattern would confuse:
- A mute with soft ramping and a late `ramp_done` pulse shows whether the power-down waits for the handshake.
- A mute with ramping disabled shows whether the power-down is applied at once.
- A pin release before any ramp completion shows that an aborted mute leaves power untouched.
- An unmute from the muted state shows whether the enables return before the request drops.
- Masks with mixed bits separate the affected blocks from the unaffected ones.

The power-down levels are applied one at a time and then together. The documented sequence (deep level released, settle wait, shallow level released) checks the exact edge on which `ref_ready` rises and shows that the shallow level keeps the references alive. A behavioural model checks every output on every cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    MS_IDLE    = 2'd0,
    MS_RAMP_DN = 2'd1,
    MS_MUTED   = 2'd2,
    MS_RESTORE = 2'd3
  } mute_state_e;

endpackage

// File: rtl/pwr_sync2.sv
module pwr_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_ref_settle.sv
module pwr_ref_settle #(
  parameter int REF_SETTLE_CYCLES = 983040
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_req,
  output logic ref_en,
  output logic ref_ready
);

  localparam int CW = $clog2(REF_SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(REF_SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          en_q;
  logic          rdy_q;

  always_ff @(posedge clk) begin
    if (rst || !ref_req) begin
      en_q  <= 1'b0;
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      en_q <= 1'b1;
      if (!en_q) begin
        cnt_q <= '0;
      end else if (!rdy_q) begin
        if (cnt_q == LAST) rdy_q <= 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ref_en    = en_q;
  assign ref_ready = rdy_q;

  // R4: ready drops together with the reference enable
  p_ready_drops_r4: assert property (@(posedge clk) disable iff (rst)
    !ref_req |=> (!ref_ready && !ref_en));

  // R4: ready only rises while references have been on
  p_ready_after_en_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_ready) |-> (ref_en && $past(ref_en)));

endmodule

// File: rtl/pwr_mute_seq.sv
module pwr_mute_seq
  import pwr_seq_pkg::*;
#(
  parameter int UNMUTE_HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mute_sync,
  input  logic soft_ramp_en,
  input  logic ramp_done,
  output logic mute_req,
  output logic mute_pd
);

  localparam int HW = $clog2(UNMUTE_HOLD + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(UNMUTE_HOLD - 1);

  mute_state_e   st_q, st_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          req_q, pd_q;

  always_comb begin
    st_d   = st_q;
    hold_d = hold_q;
    unique case (st_q)
      MS_IDLE: begin
        if (mute_sync) st_d = soft_ramp_en ? MS_RAMP_DN : MS_MUTED;
      end
      MS_RAMP_DN: begin
        if (!mute_sync)     st_d = MS_IDLE;
        else if (ramp_done) st_d = MS_MUTED;
      end
      MS_MUTED: begin
        if (!mute_sync) begin
          st_d   = MS_RESTORE;
          hold_d = '0;
        end
      end
      MS_RESTORE: begin
        if (hold_q == HOLD_LAST) st_d = MS_IDLE;
        else                     hold_d = hold_q + 1'b1;
      end
      default: st_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= MS_IDLE;
      hold_q <= '0;
      req_q  <= 1'b0;
      pd_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_d;
      req_q  <= (st_d != MS_IDLE);
      pd_q   <= (st_d == MS_MUTED);
    end
  end

  assign mute_req = req_q;
  assign mute_pd  = pd_q;

  // R8: power-down never stands without an active mute request
  p_pd_with_req_r8: assert property (@(posedge clk) disable iff (rst)
    mute_pd |-> mute_req);

  // R8: with ramping, no power-down while waiting for the ramp
  p_wait_ramp_r8: assert property (@(posedge clk) disable iff (rst)
    (req_q && !pd_q && st_q == MS_RAMP_DN && !ramp_done) |=> !mute_pd);

  // R9: without ramping, power-down comes with the request
  p_no_soft_r9: assert property (@(posedge clk) disable iff (rst)
    ($rose(mute_req) && !$past(soft_ramp_en)) |-> mute_pd);

  // R10: request drops only after the power-down was already lifted
  p_unmute_order_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(mute_req) |-> (!mute_pd && !$past(mute_pd)));

endmodule

// File: rtl/pwr_gate_bank.sv
module pwr_gate_bank #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             allow,
  input  logic             mute_pd,
  input  logic [WIDTH-1:0] pdn,
  input  logic [WIDTH-1:0] mute_mask,
  output logic [WIDTH-1:0] en
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_cell
    logic en_q;
    always_ff @(posedge clk) begin
      if (rst) en_q <= 1'b0;
      else     en_q <= allow && !pdn[g] && !(mute_pd && mute_mask[g]);
    end
    assign en[g] = en_q;

    // R11: a cell outside the mute mask ignores the mute power-down
    p_unmasked_r11: assert property (@(posedge clk) disable iff (rst)
      (allow && !pdn[g] && !mute_mask[g]) |=> en[g]);
  end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int NUM_ADC           = 4,
  parameter int NUM_BIAS          = 3,
  parameter int REF_SETTLE_CYCLES = 983040,
  parameter int UNMUTE_HOLD       = 2,
  parameter int SYNC_STAGES       = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mute_pin,
  input  logic                pdn_deep,
  input  logic                pdn_shallow,
  input  logic [NUM_ADC-1:0]  adc_pdn,
  input  logic [NUM_BIAS-1:0] bias_pdn,
  input  logic [NUM_ADC-1:0]  mute_adc_mask,
  input  logic [NUM_BIAS-1:0] mute_bias_mask,
  input  logic                soft_ramp_en,
  input  logic                ramp_done,
  output logic                ref_en,
  output logic                ref_ready,
  output logic [NUM_ADC-1:0]  adc_en,
  output logic [NUM_BIAS-1:0] bias_en,
  output logic                mute_req
);

  logic mute_sync;
  logic mute_pd;
  logic blocks_allowed;

  pwr_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (mute_pin),
    .sync_out (mute_sync)
  );

  pwr_ref_settle #(.REF_SETTLE_CYCLES(REF_SETTLE_CYCLES)) u_ref (
    .clk       (clk),
    .rst       (rst),
    .ref_req   (!pdn_deep),
    .ref_en    (ref_en),
    .ref_ready (ref_ready)
  );

  pwr_mute_seq #(.UNMUTE_HOLD(UNMUTE_HOLD)) u_mute (
    .clk          (clk),
    .rst          (rst),
    .mute_sync    (mute_sync),
    .soft_ramp_en (soft_ramp_en),
    .ramp_done    (ramp_done),
    .mute_req     (mute_req),
    .mute_pd      (mute_pd)
  );

  assign blocks_allowed = !pdn_deep && !pdn_shallow && ref_ready;

  pwr_gate_bank #(.WIDTH(NUM_ADC)) u_adc_bank (
    .clk       (clk),
    .rst       (rst),
    .allow     (blocks_allowed),
    .mute_pd   (mute_pd),
    .pdn       (adc_pdn),
    .mute_mask (mute_adc_mask),
    .en        (adc_en)
  );

  pwr_gate_bank #(.WIDTH(NUM_BIAS)) u_bias_bank (
    .clk       (clk),
    .rst       (rst),
    .allow     (blocks_allowed),
    .mute_pd   (mute_pd),
    .pdn       (bias_pdn),
    .mute_mask (mute_bias_mask),
    .en        (bias_en)
  );

  // R1: reset clears every output
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!ref_en && !ref_ready && adc_en == '0 && bias_en == '0 && !mute_req));

  // R2: deep level turns references and all blocks off
  p_deep_off_r2: assert property (@(posedge clk) disable iff (rst)
    pdn_deep |=> (!ref_en && !ref_ready && adc_en == '0 && bias_en == '0));

  // R3: shallow level keeps references, blocks off
  p_shallow_off_r3: assert property (@(posedge clk) disable iff (rst)
    (pdn_shallow && !pdn_deep) |=> (ref_en && adc_en == '0 && bias_en == '0));

  // R5: no channel enable without settled references one cycle earlier
  p_adc_needs_ready_r5: assert property (@(posedge clk) disable iff (rst)
    (adc_en != '0) |-> $past(ref_ready));

endmodule

// File: tb/pwr_seq_ctrl_test.sv
module pwr_seq_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NA = 4;
  localparam int NB = 3;
  localparam int SETTLE = 16;
  localparam int HOLD = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mute_pin = 1'b0, pdn_deep = 1'b0, pdn_shallow = 1'b0;
  logic [NA-1:0] adc_pdn = '0, amask = 4'b0101;
  logic [NB-1:0] bias_pdn = '0, bmask = 3'b001;
  logic soft_ramp_en = 1'b1, ramp_done = 1'b0;
  logic ref_en, ref_ready, mute_req;
  logic [NA-1:0] adc_en;
  logic [NB-1:0] bias_en;

  int checks = 0;
  int errors = 0;
  bit model_on = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_ctrl #(.NUM_ADC(NA), .NUM_BIAS(NB), .REF_SETTLE_CYCLES(SETTLE),
                 .UNMUTE_HOLD(HOLD), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .mute_pin(mute_pin), .pdn_deep(pdn_deep),
    .pdn_shallow(pdn_shallow), .adc_pdn(adc_pdn), .bias_pdn(bias_pdn),
    .mute_adc_mask(amask), .mute_bias_mask(bmask), .soft_ramp_en(soft_ramp_en),
    .ramp_done(ramp_done), .ref_en(ref_en), .ref_ready(ref_ready),
    .adc_en(adc_en), .bias_en(bias_en), .mute_req(mute_req));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference model
  int  p1 = 0, p2 = 0;
  int  mode = 0;           // 0 unmuted, 1 waiting ramp, 2 muted, 3 restoring
  int  wait_n = 0;
  int  settle_n = 0;
  bit  m_ref = 0, m_rdy = 0, m_req = 0, m_pd = 0;
  bit  m_adc[NA];
  bit  m_bias[NB];

  always @(posedge clk) begin
    bit ok_blk;
    ok_blk = !rst && !pdn_deep && !pdn_shallow && m_rdy;
    for (int i = 0; i < NA; i++) m_adc[i] <= ok_blk && !adc_pdn[i] && !(m_pd && amask[i]);
    for (int i = 0; i < NB; i++) m_bias[i] <= ok_blk && !bias_pdn[i] && !(m_pd && bmask[i]);
    if (rst || pdn_deep) begin
      m_ref <= 0; m_rdy <= 0; settle_n <= 0;
    end else begin
      m_ref <= 1;
      if (m_ref && !m_rdy) begin
        settle_n <= settle_n + 1;
        if (settle_n + 1 == SETTLE) m_rdy <= 1;
      end
    end
    p1 <= rst ? 0 : int'(mute_pin);
    p2 <= rst ? 0 : p1;
    if (rst) begin
      mode <= 0; m_req <= 0; m_pd <= 0; wait_n <= 0;
    end else if (mode == 0 && p2 == 1) begin
      mode <= soft_ramp_en ? 1 : 2; m_req <= 1; m_pd <= !soft_ramp_en;
    end else if (mode == 1 && p2 == 0) begin
      mode <= 0; m_req <= 0;
    end else if (mode == 1 && ramp_done) begin
      mode <= 2; m_pd <= 1;
    end else if (mode == 2 && p2 == 0) begin
      mode <= 3; m_pd <= 0; wait_n <= 0;
    end else if (mode == 3) begin
      if (wait_n + 1 == HOLD) begin mode <= 0; m_req <= 0; end
      else wait_n <= wait_n + 1;
    end
    model_on <= 1;
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      int ea, eb;
      ea = 0; eb = 0;
      for (int i = 0; i < NA; i++) ea |= int'(m_adc[i]) << i;
      for (int i = 0; i < NB; i++) eb |= int'(m_bias[i]) << i;
      check("R2 model ref_en", int'(ref_en), int'(m_ref));
      check("R4 model ref_ready", int'(ref_ready), int'(m_rdy));
      check("R5 model adc_en", int'(adc_en), ea);
      check("R6 model bias_en", int'(bias_en), eb);
      check("R7 model mute_req", int'(mute_req), int'(m_req));
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    check("R1 reset ref_en", int'(ref_en), 0);
    check("R1 reset ref_ready", int'(ref_ready), 0);
    check("R1 reset adc_en", int'(adc_en), 0);
    check("R1 reset bias_en", int'(bias_en), 0);
    check("R1 reset mute_req", int'(mute_req), 0);
    rst = 1'b0;
    tick(1);
    check("R4 ref_en up", int'(ref_en), 1);
    check("R4 ready early", int'(ref_ready), 0);
    tick(SETTLE - 1);
    check("R4 ready one before", int'(ref_ready), 0);
    tick(1);
    check("R4 ready at settle", int'(ref_ready), 1);
    check("R5 adc held before ready", int'(adc_en), 0);
    tick(1);
    check("R5 adc after ready", int'(adc_en), 'hF);
    check("R6 bias after ready", int'(bias_en), 'h7);
    adc_pdn = 4'b0010; tick(1);
    check("R5 single adc pdn", int'(adc_en), 'hD);
    adc_pdn = '0; bias_pdn = 3'b100; tick(1);
    check("R6 single bias pdn", int'(bias_en), 'h3);
    bias_pdn = '0; tick(1);
    // soft mute
    mute_pin = 1'b1; tick(2);
    check("R7 req after two edges", int'(mute_req), 0);
    tick(1);
    check("R7 req on third edge", int'(mute_req), 1);
    tick(4);
    check("R8 adc wait ramp", int'(adc_en), 'hF);
    ramp_done = 1'b1; tick(1); ramp_done = 1'b0;
    check("R8 adc same edge as done", int'(adc_en), 'hF);
    tick(1);
    check("R8 masked adc off", int'(adc_en), 'hA);
    check("R11 unmasked bias kept", int'(bias_en), 'h6);
    // unmute
    mute_pin = 1'b0; tick(3);
    check("R10 req held", int'(mute_req), 1);
    check("R10 adc still off", int'(adc_en), 'hA);
    tick(1);
    check("R10 adc restored", int'(adc_en), 'hF);
    check("R10 bias restored", int'(bias_en), 'h7);
    check("R10 req still high", int'(mute_req), 1);
    tick(1);
    check("R10 req drops", int'(mute_req), 0);
    // hard mute
    soft_ramp_en = 1'b0; mute_pin = 1'b1; tick(3);
    check("R9 req up", int'(mute_req), 1);
    check("R9 adc before", int'(adc_en), 'hF);
    tick(1);
    check("R9 masked adc off", int'(adc_en), 'hA);
    mute_pin = 1'b0; tick(5);
    check("R9 recovered req", int'(mute_req), 0);
    check("R9 recovered adc", int'(adc_en), 'hF);
    soft_ramp_en = 1'b1;
    // aborted mute
    mute_pin = 1'b1; tick(3);
    check("R12 req up", int'(mute_req), 1);
    mute_pin = 1'b0; tick(2);
    check("R12 req pending", int'(mute_req), 1);
    check("R12 adc untouched", int'(adc_en), 'hF);
    tick(1);
    check("R12 req drops", int'(mute_req), 0);
    check("R12 bias untouched", int'(bias_en), 'h7);
    // global levels
    pdn_shallow = 1'b1; tick(1);
    check("R3 adc off", int'(adc_en), 0);
    check("R3 bias off", int'(bias_en), 0);
    check("R3 ref kept", int'(ref_en), 1);
    check("R3 ready kept", int'(ref_ready), 1);
    pdn_deep = 1'b1; tick(1);
    check("R2 ref off", int'(ref_en), 0);
    check("R2 ready off", int'(ref_ready), 0);
    pdn_deep = 1'b0; tick(1);
    check("R4 ref back", int'(ref_en), 1);
    tick(SETTLE - 1);
    check("R4 ready not yet", int'(ref_ready), 0);
    tick(1);
    check("R4 ready resettled", int'(ref_ready), 1);
    check("R3 adc held by shallow", int'(adc_en), 0);
    pdn_shallow = 1'b0; tick(1);
    check("R5 adc after sequence", int'(adc_en), 'hF);
    rst = 1'b1; tick(1);
    check("R1 mid reset adc", int'(adc_en), 0);
    check("R1 mid reset ref", int'(ref_en), 0);
    rst = 1'b0; tick(SETTLE + 3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule